// File: doc/BRIEF.md
# Mailbox Handshake State Monitor

This block sits beside a shared mailbox RAM and watches byte writes into two small state windows: one holding a handshake state byte for each outgoing (send) channel and one holding a state byte for each incoming (receive) channel. Each channel's slot is one deep. Its state steps through idle, new, received and complete. On send channels the host posts new, the coprocessor advances the state to received and then to complete, and the host returns it to idle once it has read the reply. Receive channels run the same steps with the roles swapped.

The monitor keeps a shadow copy of every channel state. It raises a send-direction attention flag when a send channel moves into complete, and a receive-direction flag when a receive channel moves into new. A per-direction pending mask tells the host which channels to service. The host clears a flag with a one-cycle acknowledge pulse. The snoop input is a valid-qualified byte write. It has no ready: every write is taken in the cycle it appears, and the block never applies back-pressure. Flags, masks, acknowledges and the shadow read port are plain level or pulse signals.

Top module: `mbx_state_monitor`

## Requirements
- R1: After reset every shadow state reads 0 (idle), both pending masks are 0 and both flags are low.
- R2: State encoding is idle=0, new=1, received=2, complete=3. A write with `snp_valid` high to address SEND_BASE+c (default 0x100+c) or RECV_BASE+c (default 0x180+c), for c in 0..6, stores the byte as channel c's send or receive state. `rd_state` shows that byte from the cycle after the write. A read of channel 7 returns 0.
- R3: A write of 3 to a send channel whose shadow is not 3 sets that channel's bit in `send_pend` and raises `send_flag`, both visible the cycle after the write.
- R4: A write of 1 to a receive channel whose shadow is not 1 sets that channel's bit in `recv_pend` and raises `recv_flag`, both visible the cycle after the write.
- R5: Rewriting a channel's current trigger value raises nothing new. Writing any non-trigger value, including the codes 4 to 255, stores it and raises nothing.
- R6: A pending bit clears when its channel's state is written with a value different from its shadow. Rewriting the same value leaves the bit unchanged.
- R7: An acknowledge pulse clears its direction's flag if that direction's pending mask is 0 after the cycle. Otherwise the flag stays high. Without an acknowledge or an event, the flag holds.
- R8: If a trigger transition and an acknowledge for the same direction fall in one cycle, the flag is high afterwards.
- R9: Writes with `snp_valid` low, and writes to addresses outside both windows, change no state, mask or flag.
- R10: An acknowledge for one direction has no effect on the other direction's flag or mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| snp_valid | input | 1 | Snooped RAM byte write is present this cycle |
| snp_addr | input | 16 | Byte address of the snooped write |
| snp_data | input | 8 | Byte being written |
| send_ack | input | 1 | Host acknowledge pulse for the send flag |
| recv_ack | input | 1 | Host acknowledge pulse for the receive flag |
| rd_recv | input | 1 | Shadow read port direction select: 1 is receive, 0 is send |
| rd_chan | input | 3 | Shadow read port channel |
| rd_state | output | 8 | Shadow state of the selected channel |
| send_flag | output | 1 | Send channel reached complete |
| recv_flag | output | 1 | Receive channel reached new |
| send_pend | output | 7 | Send channels awaiting service |
| recv_pend | output | 7 | Receive channels awaiting service |

## Verification
A trigger write and an acknowledge for the same direction can land in one cycle. The bench provokes this by pulsing the acknowledge in the same cycle that it writes the trigger code. The scoreboard then expects the flag high and the new pending bit set. The bench also pairs an acknowledge with a same-value rewrite, and with a pending bit that stays set, to tell these cases apart from a true clear.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  typedef enum logic [7:0] {
    HS_IDLE = 8'd0,
    HS_NEW  = 8'd1,
    HS_RCVD = 8'd2,
    HS_DONE = 8'd3
  } hs_state_e;

  localparam int unsigned STATE_W = 8;
endpackage

// File: rtl/mbx_win_decode.sv
module mbx_win_decode #(
  parameter int unsigned ADDR_W   = 16,
  parameter int unsigned BASE     = 16'h0100,
  parameter int unsigned NUM_CHAN = 7,
  localparam int unsigned CH_W    = $clog2(NUM_CHAN)
) (
  input  logic              valid,
  input  logic [ADDR_W-1:0] addr,
  output logic              hit,
  output logic [CH_W-1:0]   chan
);
  localparam logic [ADDR_W-1:0] BASE_A = BASE[ADDR_W-1:0];
  localparam logic [ADDR_W-1:0] SPAN_A = NUM_CHAN[ADDR_W-1:0];

  logic [ADDR_W-1:0] offset;

  always_comb begin
    offset = addr - BASE_A;
    hit    = valid && (addr >= BASE_A) && (offset < SPAN_A);
    chan   = offset[CH_W-1:0];
  end
endmodule

// File: rtl/mbx_dir_bank.sv
module mbx_dir_bank
  import mbx_pkg::*;
#(
  parameter int unsigned NUM_CHAN = 7,
  parameter logic [7:0]  TRIG     = 8'd3,
  localparam int unsigned CH_W    = $clog2(NUM_CHAN)
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               wr_hit,
  input  logic [CH_W-1:0]                    wr_chan,
  input  logic [STATE_W-1:0]                 wr_data,
  output logic [NUM_CHAN-1:0][STATE_W-1:0]   shadow,
  output logic [NUM_CHAN-1:0]                pend,
  output logic [NUM_CHAN-1:0]                pend_nx,
  output logic                               evt
);
  logic [NUM_CHAN-1:0] ch_evt;

  for (genvar i = 0; i < NUM_CHAN; i++) begin : g_ch
    logic sel;
    logic changed;

    always_comb begin
      sel        = wr_hit && (wr_chan == CH_W'(i));
      changed    = sel && (wr_data != shadow[i]);
      ch_evt[i]  = changed && (wr_data == TRIG);
      if (ch_evt[i])    pend_nx[i] = 1'b1;
      else if (changed) pend_nx[i] = 1'b0;
      else              pend_nx[i] = pend[i];
    end

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        shadow[i] <= HS_IDLE;
        pend[i]   <= 1'b0;
      end else begin
        if (sel) shadow[i] <= wr_data;
        pend[i] <= pend_nx[i];
      end
    end

    // R3 / R4: entering the trigger state marks the channel pending
    assert_entry_marks_pend_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_hit && wr_chan == CH_W'(i) && wr_data == TRIG && shadow[i] != TRIG) |=> pend[i]);

    // R9: a pending bit only rises after a write into this channel's window
    assert_pend_needs_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pend[i]) |-> $past(wr_hit && wr_chan == CH_W'(i)));

    // R2: the shadow holds the byte written in the previous cycle
    assert_shadow_store_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_hit && wr_chan == CH_W'(i)) |=> (shadow[i] == $past(wr_data)));

    // R6: a rewrite of the same value leaves the pending bit alone
    assert_same_value_keeps_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_hit && wr_chan == CH_W'(i) && wr_data == shadow[i]) |=> (pend[i] == $past(pend[i])));
  end

  assign evt = |ch_evt;
endmodule

// File: rtl/mbx_irq_flag.sv
module mbx_irq_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic evt,
  input  logic ack,
  input  logic pend_any_nx,
  output logic flag
);
  always_ff @(posedge clk) begin
    if (!rst_n)      flag <= 1'b0;
    else if (evt)    flag <= 1'b1;
    else if (ack)    flag <= pend_any_nx;
  end

  // R8: an event wins over a same-cycle acknowledge
  assert_event_sets_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
    evt |=> flag);

  // R7: acknowledge with nothing left pending clears the flag
  assert_ack_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !evt && !pend_any_nx) |=> !flag);

  // R7: with neither event nor acknowledge the flag holds
  assert_flag_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!ack && !evt) |=> $stable(flag));
endmodule

// File: rtl/mbx_state_monitor.sv
module mbx_state_monitor
  import mbx_pkg::*;
#(
  parameter int unsigned ADDR_W    = 16,
  parameter int unsigned NUM_CHAN  = 7,
  parameter int unsigned SEND_BASE = 16'h0100,
  parameter int unsigned RECV_BASE = 16'h0180,
  localparam int unsigned CH_W     = $clog2(NUM_CHAN)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                snp_valid,
  input  logic [ADDR_W-1:0]   snp_addr,
  input  logic [7:0]          snp_data,
  input  logic                send_ack,
  input  logic                recv_ack,
  input  logic                rd_recv,
  input  logic [CH_W-1:0]     rd_chan,
  output logic [7:0]          rd_state,
  output logic                send_flag,
  output logic                recv_flag,
  output logic [NUM_CHAN-1:0] send_pend,
  output logic [NUM_CHAN-1:0] recv_pend
);
  logic                              s_hit, r_hit;
  logic [CH_W-1:0]                   s_chan, r_chan;
  logic [NUM_CHAN-1:0][STATE_W-1:0]  s_shadow, r_shadow;
  logic [NUM_CHAN-1:0]               s_pnx, r_pnx;
  logic                              s_evt, r_evt;

  mbx_win_decode #(.ADDR_W(ADDR_W), .BASE(SEND_BASE), .NUM_CHAN(NUM_CHAN)) u_sdec (
    .valid(snp_valid), .addr(snp_addr), .hit(s_hit), .chan(s_chan));

  mbx_win_decode #(.ADDR_W(ADDR_W), .BASE(RECV_BASE), .NUM_CHAN(NUM_CHAN)) u_rdec (
    .valid(snp_valid), .addr(snp_addr), .hit(r_hit), .chan(r_chan));

  mbx_dir_bank #(.NUM_CHAN(NUM_CHAN), .TRIG(HS_DONE)) u_sbank (
    .clk(clk), .rst_n(rst_n), .wr_hit(s_hit), .wr_chan(s_chan), .wr_data(snp_data),
    .shadow(s_shadow), .pend(send_pend), .pend_nx(s_pnx), .evt(s_evt));

  mbx_dir_bank #(.NUM_CHAN(NUM_CHAN), .TRIG(HS_NEW)) u_rbank (
    .clk(clk), .rst_n(rst_n), .wr_hit(r_hit), .wr_chan(r_chan), .wr_data(snp_data),
    .shadow(r_shadow), .pend(recv_pend), .pend_nx(r_pnx), .evt(r_evt));

  mbx_irq_flag u_sflag (
    .clk(clk), .rst_n(rst_n), .evt(s_evt), .ack(send_ack),
    .pend_any_nx(|s_pnx), .flag(send_flag));

  mbx_irq_flag u_rflag (
    .clk(clk), .rst_n(rst_n), .evt(r_evt), .ack(recv_ack),
    .pend_any_nx(|r_pnx), .flag(recv_flag));

  always_comb begin
    rd_state = HS_IDLE;
    if (int'(rd_chan) < NUM_CHAN)
      rd_state = rd_recv ? r_shadow[rd_chan] : s_shadow[rd_chan];
  end

  // R10: the two directions never address the same byte
  assert_windows_disjoint_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(s_hit && r_hit));

  // R9: with no valid write, neither mask changes
  assert_idle_keeps_masks_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !snp_valid |=> ($stable(send_pend) && $stable(recv_pend)));
endmodule

// File: tb/mbx_state_monitor_test.sv
module mbx_state_monitor_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        snp_valid = 1'b0;
  logic [15:0] snp_addr = '0;
  logic [7:0]  snp_data = '0;
  logic        send_ack = 1'b0, recv_ack = 1'b0;
  logic        rd_recv = 1'b0;
  logic [2:0]  rd_chan = '0;
  logic [7:0]  rd_state;
  logic        send_flag, recv_flag;
  logic [6:0]  send_pend, recv_pend;

  always #5 clk = ~clk;

  mbx_state_monitor uut (
    .clk(clk), .rst_n(rst_n), .snp_valid(snp_valid), .snp_addr(snp_addr),
    .snp_data(snp_data), .send_ack(send_ack), .recv_ack(recv_ack),
    .rd_recv(rd_recv), .rd_chan(rd_chan), .rd_state(rd_state),
    .send_flag(send_flag), .recv_flag(recv_flag),
    .send_pend(send_pend), .recv_pend(recv_pend));

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  // expected model
  logic [7:0] m_s [7];
  logic [7:0] m_r [7];
  logic [6:0] m_sp = '0, m_rp = '0;
  logic       m_sf = 1'b0, m_rf = 1'b0;

  typedef struct packed {
    logic       sf;
    logic       rf;
    logic [6:0] sp;
    logic [6:0] rp;
    logic [7:0] rd;
  } exp_t;

  exp_t  q_exp [$];
  string q_tag [$];

  task automatic step(input bit v, input logic [15:0] a, input logic [7:0] d,
                      input bit as, input bit ar, input bit rr, input logic [2:0] rc,
                      input string tag);
    bit hs, hr, ev;
    int c;
    exp_t e;
    hs = 1'b0; hr = 1'b0; ev = 1'b0; c = 0;
    if (v && a >= 16'h0100 && a < 16'h0107) begin hs = 1'b1; c = int'(a - 16'h0100); end
    if (v && a >= 16'h0180 && a < 16'h0187) begin hr = 1'b1; c = int'(a - 16'h0180); end
    if (hs) begin
      if (d != m_s[c]) begin
        ev = (d == 8'd3);
        m_sp[c] = ev;
      end
      m_s[c] = d;
    end
    m_sf = ev ? 1'b1 : (as ? |m_sp : m_sf);
    ev = 1'b0;
    if (hr) begin
      if (d != m_r[c]) begin
        ev = (d == 8'd1);
        m_rp[c] = ev;
      end
      m_r[c] = d;
    end
    m_rf = ev ? 1'b1 : (ar ? |m_rp : m_rf);
    e.sf = m_sf; e.rf = m_rf; e.sp = m_sp; e.rp = m_rp;
    e.rd = (rc > 3'd6) ? 8'd0 : (rr ? m_r[rc] : m_s[rc]);
    @(negedge clk);
    snp_valid = v; snp_addr = a; snp_data = d;
    send_ack = as; recv_ack = ar; rd_recv = rr; rd_chan = rc;
    q_exp.push_back(e);
    q_tag.push_back(tag);
  endtask

  // monitor: compare each queued expectation after the edge it belongs to
  initial begin
    forever begin
      @(posedge clk);
      if (q_exp.size() > 0) begin
        exp_t e;
        string t;
        exp_t got;
        e = q_exp.pop_front();
        t = q_tag.pop_front();
        #2;
        got.sf = send_flag; got.rf = recv_flag; got.sp = send_pend;
        got.rp = recv_pend; got.rd = rd_state;
        total++;
        if (got !== e) begin
          bad++;
          $display("FAIL %s: got sf=%0b rf=%0b sp=%h rp=%h rd=%h expected sf=%0b rf=%0b sp=%h rp=%h rd=%h",
                   t, got.sf, got.rf, got.sp, got.rp, got.rd, e.sf, e.rf, e.sp, e.rp, e.rd);
        end
      end
    end
  end

  initial begin
    #1000000;
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog: got hung run expected completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 7; i++) begin m_s[i] = 8'd0; m_r[i] = 8'd0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    total++;
    if (send_flag !== 1'b0 || recv_flag !== 1'b0 || send_pend !== 7'd0 ||
        recv_pend !== 7'd0 || rd_state !== 8'd0) begin
      bad++;
      $display("FAIL R1 reset: got sf=%0b rf=%0b sp=%h rp=%h rd=%h expected all zero",
               send_flag, recv_flag, send_pend, recv_pend, rd_state);
    end
    step(1, 16'h0102, 8'd1, 0, 0, 0, 3'd2, "R2 send ch2 new stored");
    step(1, 16'h0102, 8'd2, 0, 0, 0, 3'd2, "R2 send ch2 rcvd stored");
    step(1, 16'h0102, 8'd3, 0, 0, 0, 3'd2, "R3 send ch2 complete raises");
    step(1, 16'h0102, 8'd3, 1, 0, 0, 3'd2, "R5 R7 rewrite plus ack keeps flag");
    step(1, 16'h0102, 8'd0, 0, 0, 0, 3'd2, "R6 idle clears pend");
    step(0, 16'h0000, 8'd0, 1, 0, 0, 3'd2, "R7 ack clears send flag");
    step(1, 16'h0186, 8'd1, 0, 0, 1, 3'd6, "R4 recv ch6 new raises");
    step(1, 16'h0180, 8'd1, 0, 1, 1, 3'd0, "R8 event with ack");
    step(0, 16'h0000, 8'd0, 1, 0, 1, 3'd6, "R10 send ack leaves recv");
    step(1, 16'h0186, 8'd2, 0, 0, 1, 3'd6, "R6 recv ch6 rcvd clears bit");
    step(0, 16'h0000, 8'd0, 0, 1, 1, 3'd0, "R7 ack with pending keeps flag");
    step(1, 16'h0180, 8'h7E, 0, 0, 1, 3'd0, "R5 R6 odd code stored no flag");
    step(0, 16'h0000, 8'd0, 0, 1, 1, 3'd0, "R7 ack clears recv flag");
    step(1, 16'h0107, 8'd3, 0, 0, 0, 3'd6, "R9 address past send window");
    step(1, 16'h017F, 8'd1, 0, 0, 1, 3'd6, "R9 address below recv window");
    step(0, 16'h0100, 8'd3, 0, 0, 0, 3'd0, "R9 valid low ignored");
    step(1, 16'h0106, 8'd3, 1, 0, 0, 3'd6, "R8 send event with ack");
    step(1, 16'h0105, 8'd5, 0, 0, 0, 3'd5, "R5 code 5 stored no flag");
    step(1, 16'h0186, 8'd1, 0, 0, 1, 3'd7, "R2 channel 7 reads zero R4");
    step(0, 16'h0000, 8'd0, 0, 1, 0, 3'd6, "R10 recv ack leaves send");
    step(0, 16'h0000, 8'd0, 0, 0, 0, 3'd6, "R7 hold without ack");
    repeat (3) @(negedge clk);
    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule